// File: doc/BRIEF.md
# Serial Line Receiver with Stream Output

This block turns asynchronous serial frames arriving on one input wire into parallel words. Each frame is one low start bit, then the data bits, least significant first, then one high stop bit. Completed words go out on a valid/ready stream port. A receiving client takes a word by holding ready high in a cycle where valid is high.

The bit rate is set at run time through a prescale input: prescale = clock frequency / (8 × baud rate), so one bit lasts 8 × prescale clock cycles. The prescale value is captured when a start edge is seen, so a new value takes effect from the next frame. A zero prescale is treated as one.

Two single-cycle error pulses are produced. A bad stop bit drops the word and raises the framing pulse. A word that completes while the previous word is still unread replaces that word and raises the overrun pulse. A busy output marks a frame in progress.

Top module: `serial_rx_stream`

## Requirements
- R1: After synchronous reset, `m_tvalid`, `busy`, `overrun_err` and `frame_err` are all low.
- R2: A frame sent at 8 × prescale clocks per bit is presented as a word on `m_tdata`, with data bit 0 taken from the first data bit after the start bit, and `m_tvalid` high no later than the end of the stop bit.
- R3: While `m_tvalid` is high and `m_tready` is low, and no new word arrives, `m_tvalid` and `m_tdata` hold. A cycle with both `m_tvalid` and `m_tready` high consumes the word, and `m_tvalid` drops unless a new word is loaded in that same cycle.
- R4: A word that completes while an unconsumed word is held replaces it and pulses `overrun_err`. If the held word is consumed in the completion cycle, there is no overrun and the new word is shown.
- R5: A stop bit sampled low pulses `frame_err`, discards the word and leaves `m_tvalid` unchanged.
- R6: A low pulse on an idle line that has ended before the half-bit recheck returns the receiver to idle with no word and no error. A following good frame is received normally.
- R7: `busy` is high while a frame is being received and low once the stop bit has been sampled.
- R8: Prescale is captured at the start edge. A change to the input during a frame does not affect that frame.
- R9: A prescale of 0 behaves as a prescale of 1.
- R10: `frame_err` and `overrun_err` are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxd | input | 1 | Serial line input, idle high, asynchronous |
| prescale | input | PRE_W | Clocks per one-eighth bit |
| m_tdata | output | DATA_W | Received word |
| m_tvalid | output | 1 | Word available |
| m_tready | input | 1 | Client takes the word |
| busy | output | 1 | Frame in progress |
| overrun_err | output | 1 | One-cycle pulse: unread word replaced |
| frame_err | output | 1 | One-cycle pulse: stop bit was low |

## Verification
A word can complete in the same cycle that the client accepts the previous word. The consume and the load of the output register then fall on one clock edge. To provoke this, one word is left unread, a second frame is sent, and a one-cycle ready pulse is swept across a window of clock offsets around the second frame's stop-bit sample. In each run, the bench records the data value visible while ready is high. If that value was the first word, no overrun may follow and the second word must still be waiting. If it was already the second word, exactly one overrun pulse is expected and the output must be empty afterwards.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;

  // Oversampling ratio of the prescale input.
  localparam int unsigned OVERSAMPLE = 8;

  // A zero prescale runs as one.
  function automatic logic [31:0] srx_eff_pre(input logic [31:0] p);
    return (p == 32'd0) ? 32'd1 : p;
  endfunction

  // Clock cycles in one full bit period.
  function automatic logic [31:0] srx_bit_cycles(input logic [31:0] p);
    return srx_eff_pre(p) * OVERSAMPLE;
  endfunction

  // Clock cycles from the start edge to the start-bit recheck.
  function automatic logic [31:0] srx_half_cycles(input logic [31:0] p);
    return srx_eff_pre(p) * (OVERSAMPLE / 2);
  endfunction

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx,
  input  logic [PRE_W-1:0]  prescale,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] word,
  output logic              ferr
);
  localparam int CNT_W = PRE_W + 3;
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic [PRE_W-1:0]  pre_q;
  logic              rx_prev;
  logic              ferr_q;

  // Named internal events.
  logic tick, fall_seen, start_ok, start_glitch, bit_take, stop_take;
  logic [CNT_W-1:0] bit_reload;

  assign tick         = (cnt == '0);
  assign fall_seen    = (state == RX_IDLE) && rx_prev && !rx;
  assign start_ok     = (state == RX_START) && tick && !rx;
  assign start_glitch = (state == RX_START) && tick && rx;
  assign bit_take     = (state == RX_DATA) && tick;
  assign stop_take    = (state == RX_STOP) && tick;
  assign bit_reload   = CNT_W'(srx_bit_cycles(32'(pre_q)) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      pre_q   <= PRE_W'(1);
      rx_prev <= 1'b1;
      ferr_q  <= 1'b0;
    end else begin
      rx_prev <= rx;
      ferr_q  <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (fall_seen) begin
            state <= RX_START;
            pre_q <= PRE_W'(srx_eff_pre(32'(prescale)));
            cnt   <= CNT_W'(srx_half_cycles(32'(prescale)) - 32'd1);
          end
        end
        RX_START: begin
          if (start_ok) begin
            state <= RX_DATA;
            cnt   <= bit_reload;
            idx   <= '0;
          end else if (start_glitch) begin
            state <= RX_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_DATA: begin
          if (bit_take) begin
            shreg <= {rx, shreg[DATA_W-1:1]};
            cnt   <= bit_reload;
            if (idx == LAST_IDX) state <= RX_STOP;
            else                 idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_STOP: begin
          if (stop_take) begin
            state  <= RX_IDLE;
            ferr_q <= !rx;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign busy = (state != RX_IDLE);
  assign done = stop_take && rx;
  assign word = shreg;
  assign ferr = ferr_q;

  // R10: framing pulse lasts one cycle.
  a_r10_ferr_pulse: assert property (@(posedge clk) disable iff (rst)
    ferr_q |=> !ferr_q);
  // R6: a failed start recheck returns to idle without an error.
  a_r6_glitch_idle: assert property (@(posedge clk) disable iff (rst)
    start_glitch |=> (state == RX_IDLE) && !ferr_q);
  // R8: captured prescale is frozen through a frame.
  a_r8_pre_frozen: assert property (@(posedge clk) disable iff (rst)
    (state != RX_IDLE) && $past(state != RX_IDLE) |-> $stable(pre_q));
  // R2: the bit index never runs past the word.
  a_r2_idx_bound: assert property (@(posedge clk) disable iff (rst)
    (state == RX_DATA) |-> (idx <= LAST_IDX));
  // R7: busy ends right after the stop sample.
  a_r7_busy_end: assert property (@(posedge clk) disable iff (rst)
    stop_take |=> !busy);
endmodule

// File: rtl/srx_outreg.sv
module srx_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tready,
  output logic              tvalid,
  output logic [DATA_W-1:0] tdata,
  output logic              overrun
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              ovr_q;
  logic              consume, clobber;

  assign consume = valid_q && tready;
  assign clobber = load && valid_q && !tready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      ovr_q <= clobber;
      if (load) begin
        data_q  <= load_data;
        valid_q <= 1'b1;
      end else if (consume) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign tvalid  = valid_q;
  assign tdata   = data_q;
  assign overrun = ovr_q;

  // R3: an unaccepted word holds.
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    valid_q && !tready && !load |=> valid_q && $stable(data_q));
  // R3: an accepted word leaves when nothing replaces it.
  a_r3_drop: assert property (@(posedge clk) disable iff (rst)
    valid_q && tready && !load |=> !valid_q);
  // R4: an overrun always leaves the newer word visible.
  a_r4_ovr_word: assert property (@(posedge clk) disable iff (rst)
    ovr_q |-> valid_q);
  // R10: overrun pulse lasts one cycle.
  a_r10_ovr_pulse: assert property (@(posedge clk) disable iff (rst)
    ovr_q |=> !ovr_q);
endmodule

// File: rtl/serial_rx_stream.sv
module serial_rx_stream #(
  parameter int DATA_W      = 8,
  parameter int PRE_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic [PRE_W-1:0]  prescale,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              busy,
  output logic              overrun_err,
  output logic              frame_err
);
  logic              rx_s;
  logic              word_done;
  logic [DATA_W-1:0] word_bits;

  srx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rxd),
    .q   (rx_s)
  );

  srx_frame #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .rx       (rx_s),
    .prescale (prescale),
    .busy     (busy),
    .done     (word_done),
    .word     (word_bits),
    .ferr     (frame_err)
  );

  srx_outreg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .load      (word_done),
    .load_data (word_bits),
    .tready    (m_tready),
    .tvalid    (m_tvalid),
    .tdata     (m_tdata),
    .overrun   (overrun_err)
  );

  // R5: a framing failure never delivers a word.
  a_r5_no_word: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> !$rose(m_tvalid));
  // R4/R5: the two error pulses come from exclusive outcomes.
  a_r4_err_excl: assert property (@(posedge clk) disable iff (rst)
    !(frame_err && overrun_err));
endmodule

// File: tb/serial_rx_stream_tb.sv
`timescale 1ns/1ps
module serial_rx_stream_tb;
  localparam int DW = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rxd = 1'b1;
  logic [PW-1:0] prescale = 16'd1;
  logic [DW-1:0] m_tdata;
  logic          m_tvalid;
  logic          m_tready = 1'b0;
  logic          busy, overrun_err, frame_err;

  serial_rx_stream #(.DATA_W(DW), .PRE_W(PW)) u_dut (
    .clk(clk), .rst(rst), .rxd(rxd), .prescale(prescale),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .busy(busy), .overrun_err(overrun_err), .frame_err(frame_err)
  );

  always #5 clk = ~clk;

  int vectors = 0, miscompares = 0;
  int ferr_cnt = 0, ovr_cnt = 0, wide_cnt = 0;
  logic ferr_prev = 1'b0, ovr_prev = 1'b0;
  logic busy_mid;
  bit   finished = 1'b0;

  // Pulse counters, sampled on the falling edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (frame_err) ferr_cnt++;
      if (overrun_err) ovr_cnt++;
      if ((frame_err && ferr_prev) || (overrun_err && ovr_prev)) wide_cnt++;
      ferr_prev = frame_err;
      ovr_prev  = overrun_err;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int cyc_per_bit(input int p);
    return 8 * ((p == 0) ? 1 : p);
  endfunction

  task automatic hold_line(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [DW-1:0] w, input int p, input logic stop_v);
    int nb;
    nb = cyc_per_bit(p);
    hold_line(1'b0, nb);
    busy_mid = busy;
    for (int i = 0; i < DW; i++) hold_line(w[i], nb);
    hold_line(stop_v, nb);
    rxd = 1'b1;
  endtask

  task automatic take_word();
    m_tready = 1'b1;
    @(negedge clk);
    m_tready = 1'b0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int f0, o0, d, kind_a, kind_b;
    logic took_v;
    logic [DW-1:0] took_d, w1, w2;
    bit exp_ovr;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(m_tvalid == 0, "R1 tvalid", m_tvalid, 0);
    chk(busy == 0, "R1 busy", busy, 0);
    chk(overrun_err == 0 && frame_err == 0, "R1 errors", {overrun_err, frame_err}, 0);
    repeat (4) @(negedge clk);

    // R2, R3, R7: every word at prescale 1, sampled words at 2 and 3.
    for (int p = 1; p <= 3; p++) begin
      prescale = PW'(p);
      for (int w = 0; w < 256; w += ((p == 1) ? 1 : 17)) begin
        send_frame(DW'(w), p, 1'b1);
        chk(busy_mid == 1, "R7 busy in frame", busy_mid, 1);
        chk(m_tvalid == 1, "R2 tvalid", m_tvalid, 1);
        chk(m_tdata == DW'(w), "R2 tdata", m_tdata, w);
        chk(busy == 0, "R7 busy after", busy, 0);
        take_word();
        chk(m_tvalid == 0, "R3 consumed", m_tvalid, 0);
        repeat (2) @(negedge clk);
      end
    end

    // R3: hold while not ready.
    prescale = 16'd1;
    send_frame(8'h96, 1, 1'b1);
    repeat (20) @(negedge clk);
    chk(m_tvalid == 1, "R3 hold valid", m_tvalid, 1);
    chk(m_tdata == 8'h96, "R3 hold data", m_tdata, 8'h96);
    take_word();

    // R5: bad stop bit.
    f0 = ferr_cnt;
    send_frame(8'h5A, 1, 1'b0);
    hold_line(1'b1, 16);
    chk(ferr_cnt - f0 == 1, "R5 frame_err pulse", ferr_cnt - f0, 1);
    chk(m_tvalid == 0, "R5 word dropped", m_tvalid, 0);

    // R6: short low pulse at prescale 2, then a good frame.
    prescale = 16'd2;
    f0 = ferr_cnt;
    hold_line(1'b0, 2);
    hold_line(1'b1, 24);
    chk(m_tvalid == 0, "R6 no word", m_tvalid, 0);
    chk(ferr_cnt == f0, "R6 no error", ferr_cnt - f0, 0);
    chk(busy == 0, "R6 idle", busy, 0);
    send_frame(8'hC3, 2, 1'b1);
    chk(m_tvalid == 1 && m_tdata == 8'hC3, "R6 recovers", m_tdata, 8'hC3);
    take_word();

    // R8: change prescale mid-frame.
    fork
      send_frame(8'h71, 2, 1'b1);
      begin repeat (30) @(negedge clk); prescale = 16'd5; end
    join
    chk(m_tvalid == 1 && m_tdata == 8'h71, "R8 frame unaffected", m_tdata, 8'h71);
    take_word();
    hold_line(1'b1, 4);
    send_frame(8'h2E, 5, 1'b1);
    chk(m_tvalid == 1 && m_tdata == 8'h2E, "R8 new rate applies", m_tdata, 8'h2E);
    take_word();

    // R9: zero prescale runs as one.
    prescale = 16'd0;
    send_frame(8'hB4, 0, 1'b1);
    chk(m_tvalid == 1 && m_tdata == 8'hB4, "R9 zero prescale", m_tdata, 8'hB4);
    take_word();

    // R4: sweep a one-cycle ready pulse around the second word's completion.
    prescale = 16'd1;
    w1 = 8'hA5; w2 = 8'h3C;
    kind_a = 0; kind_b = 0;
    for (int dd = 74; dd <= 82; dd++) begin
      d = dd;
      send_frame(w1, 1, 1'b1);
      o0 = ovr_cnt;
      took_v = 1'b0; took_d = '0;
      fork
        send_frame(w2, 1, 1'b1);
        begin
          repeat (d) @(negedge clk);
          m_tready = 1'b1;
          #1;
          took_v = m_tvalid;
          took_d = m_tdata;
          @(negedge clk);
          m_tready = 1'b0;
        end
      join
      repeat (3) @(negedge clk);
      exp_ovr = took_v && (took_d == w2);
      if (exp_ovr) kind_b++; else kind_a++;
      chk(took_v == 1, "R4 word present at pulse", took_v, 1);
      chk((ovr_cnt - o0) == int'(exp_ovr), "R4 overrun count", ovr_cnt - o0, int'(exp_ovr));
      chk(m_tvalid == !exp_ovr, "R4 valid after", m_tvalid, !exp_ovr);
      if (!exp_ovr)
        chk(m_tdata == w2, "R4 newer word kept", m_tdata, w2);
      if (m_tvalid) take_word();
      repeat (2) @(negedge clk);
    end
    chk(kind_a > 0 && kind_b > 0, "R4 both outcomes seen", kind_a * 16 + kind_b, 1);

    // R10: no pulse lasted more than one cycle.
    chk(wide_cnt == 0, "R10 pulse width", wide_cnt, 0);

    finished = 1'b1;
    finish_run();
  end
endmodule